// File: doc/BRIEF.md
# Excess-64 Floating-Point Multiplier

This block multiplies two numbers held in a compact 32-bit floating format. Bit 31 is the sign. Bits 30:24 hold an exponent stored with an offset of 64, so a stored value of 64 means a power of two of zero. Bits 23:0 hold a fraction whose binary point sits left of bit 23. A normalized operand has bit 23 set, which gives a value of 0.5 or more and below 1. A start strobe hands both operands to the block. A done pulse then marks the cycle in which the product and its two range flags are valid.

The fraction product is built by a serial shift-add engine that takes one multiplier bit per clock. The result sign comes from the operand signs alone. The stored exponents are added and one offset of 64 is taken back out. The double-width fraction product is brought back to normalized form with at most one left shift. It is then rounded to the nearest value, with exact halfway cases going to an even last bit. An exponent that leaves the 0..127 stored range sets a range flag. Widths are parameters, and the layout scales with them.

Top module: `fpmul_core`

## Requirements
- R1: For normalized non-zero operands with no range error, the stored result exponent is exp_a + exp_b - 64, minus one if a normalizing shift was needed, plus one if rounding carried out. The result fraction is the rounded product of the two fractions.
- R2: The result sign bit (bit 31) is the XOR of the two operand sign bits, for every non-zero, non-underflow result.
- R3: When the final stored exponent would exceed 127, overflow is 1, underflow is 0, and the result is the operand sign XOR followed by all-ones exponent and fraction fields.
- R4: When the final stored exponent would be below 0, underflow is 1, overflow is 0, and the result is all zeros. A final exponent of exactly 0 or exactly 127 raises no flag.
- R5: When bit 47 of the 48-bit fraction product is 0, the product is shifted left once and the exponent drops by one. Every normal result has fraction bit 23 set.
- R6: Rounding adds one to the kept 24 bits when the next lower bit (guard) is 1 and either any bit below it is 1 or the kept LSB is 1. An exact halfway case with an even LSB is not incremented.
- R7: If rounding carries out of the fraction, the fraction becomes 0x800000 and the exponent rises by one. This may push the result into overflow.
- R8: If the 24-bit fraction field of either operand is zero, the result is all zeros and both flags are 0.
- R9: done is high for exactly one cycle, FRAC_W+1 clock edges after the edge that samples start in the idle state.
- R10: product, overflow and underflow change only at the edge that raises done, and hold their value at all other times.
- R11: A start seen while a multiply is in progress is ignored. The running operation completes with its original operands.
- R12: After synchronous reset, done, overflow, underflow and product are all 0, and the block is idle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a multiply with opa and opb (taken only when idle) |
| opa | input | 32 | First operand: sign, excess-64 exponent, fraction |
| opb | input | 32 | Second operand, same layout |
| product | output | 32 | Rounded product, held until the next completion |
| done | output | 1 | One-cycle pulse marking a new product |
| overflow | output | 1 | Result exponent above the representable range |
| underflow | output | 1 | Result exponent below the representable range |

## Verification
The bench builds the block with its default widths: a 7-bit exponent and a 24-bit fraction. This makes the full 48-bit product and both stored-exponent extremes of 0 and 127 reachable, along with a 25-edge latency for the cycle-exact done check. A behavioural model built on 64-bit integer arithmetic predicts every product. It is compared with the outputs on every clock, so any change to the held outputs between completions is caught. Directed operands cover halfway rounding ties both ways, a rounding carry found by search (alone and pushing into overflow), and exponents exactly at the range edges. The stimulus also includes a start issued mid-operation and a start issued in the done cycle itself.

// File: rtl/fpmul_pkg.sv
package fpmul_pkg;

    localparam int DEF_EXP_W  = 7;
    localparam int DEF_FRAC_W = 24;

    typedef enum logic [0:0] {
        ST_IDLE = 1'b0,
        ST_RUN  = 1'b1
    } ctl_state_e;

    typedef struct packed {
        logic guard;
        logic sticky;
    } round_bits_t;

    typedef struct packed {
        logic ovf;
        logic unf;
    } range_flags_t;

    // nearest-even increment decision
    function automatic logic round_inc(input logic lsb, input round_bits_t rb);
        return rb.guard & (rb.sticky | lsb);
    endfunction

endpackage

// File: rtl/fpmul_shiftadd.sv
module fpmul_shiftadd #(
    parameter int W = fpmul_pkg::DEF_FRAC_W
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           load,
    input  logic [W-1:0]   a_i,
    input  logic [W-1:0]   b_i,
    output logic [2*W-1:0] prod_o,
    output logic           fin_o
);
    localparam int CNT_W = $clog2(W + 1);

    logic [W-1:0]     mcand_q;
    logic [W-1:0]     hi_q;
    logic [W-1:0]     lo_q;
    logic [CNT_W-1:0] left_q;
    logic             fin_q;
    logic [W:0]       sum;

    always_comb begin
        sum = {1'b0, hi_q} + (lo_q[0] ? {1'b0, mcand_q} : '0);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            mcand_q <= '0;
            hi_q    <= '0;
            lo_q    <= '0;
            left_q  <= '0;
            fin_q   <= 1'b0;
        end else begin
            fin_q <= 1'b0;
            if (load) begin
                mcand_q <= a_i;
                hi_q    <= '0;
                lo_q    <= b_i;
                left_q  <= CNT_W'(W);
            end else if (left_q != '0) begin
                hi_q   <= sum[W:1];
                lo_q   <= {sum[0], lo_q[W-1:1]};
                left_q <= left_q - CNT_W'(1);
                if (left_q == CNT_W'(1)) begin
                    fin_q <= 1'b1;
                end
            end
        end
    end

    assign prod_o = {hi_q, lo_q};
    assign fin_o  = fin_q;

    // R9: the engine flags completion for a single cycle only
    assert_fin_pulse_R9: assert property (@(posedge clk) disable iff (rst)
        fin_q |=> !fin_q);

endmodule

// File: rtl/fpmul_normround.sv
module fpmul_normround
    import fpmul_pkg::*;
#(
    parameter int EXP_W = DEF_EXP_W,
    parameter int W     = DEF_FRAC_W
) (
    input  logic               sign_i,
    input  logic [EXP_W-1:0]   ea_i,
    input  logic [EXP_W-1:0]   eb_i,
    input  logic               zero_i,
    input  logic [2*W-1:0]     prod_i,
    output logic [EXP_W+W:0]   result_o,
    output range_flags_t       flags_o
);
    localparam int BIAS = 2 ** (EXP_W - 1);
    localparam int EMAX = 2 ** EXP_W - 1;
    localparam int SE_W = EXP_W + 3;
    localparam logic signed [SE_W-1:0] BIAS_S = SE_W'(BIAS);
    localparam logic signed [SE_W-1:0] EMAX_S = SE_W'(EMAX);
    localparam logic signed [SE_W-1:0] ONE_S  = SE_W'(1);

    logic signed [SE_W-1:0] e_sum;
    logic signed [SE_W-1:0] e_norm;
    logic signed [SE_W-1:0] e_fin;
    logic [W-1:0]           mant;
    logic [W-1:0]           mant_f;
    logic [W:0]             mr;
    round_bits_t            rb;
    logic                   inc;

    always_comb begin
        e_sum = $signed({3'b000, ea_i}) + $signed({3'b000, eb_i}) - BIAS_S;

        if (prod_i[2*W-1]) begin
            mant      = prod_i[2*W-1:W];
            rb.guard  = prod_i[W-1];
            rb.sticky = |prod_i[W-2:0];
            e_norm    = e_sum;
        end else begin
            mant      = prod_i[2*W-2:W-1];
            rb.guard  = prod_i[W-2];
            rb.sticky = |prod_i[W-3:0];
            e_norm    = e_sum - ONE_S;
        end

        inc = round_inc(mant[0], rb);
        mr  = {1'b0, mant} + {{W{1'b0}}, inc};

        if (mr[W]) begin
            mant_f = {1'b1, {(W-1){1'b0}}};
            e_fin  = e_norm + ONE_S;
        end else begin
            mant_f = mr[W-1:0];
            e_fin  = e_norm;
        end

        flags_o.ovf = !zero_i && (e_fin > EMAX_S);
        flags_o.unf = !zero_i && (e_fin < 0);

        if (zero_i || flags_o.unf) begin
            result_o = '0;
        end else if (flags_o.ovf) begin
            result_o = {sign_i, {EXP_W{1'b1}}, {W{1'b1}}};
        end else begin
            result_o = {sign_i, e_fin[EXP_W-1:0], mant_f};
        end
    end

endmodule

// File: rtl/fpmul_core.sv
module fpmul_core
    import fpmul_pkg::*;
#(
    parameter int EXP_W  = DEF_EXP_W,
    parameter int FRAC_W = DEF_FRAC_W
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        start,
    input  logic [EXP_W+FRAC_W:0]       opa,
    input  logic [EXP_W+FRAC_W:0]       opb,
    output logic [EXP_W+FRAC_W:0]       product,
    output logic                        done,
    output logic                        overflow,
    output logic                        underflow
);
    localparam int TOT_W = 1 + EXP_W + FRAC_W;

    ctl_state_e         state_q;
    logic               sign_q;
    logic [EXP_W-1:0]   ea_q;
    logic [EXP_W-1:0]   eb_q;
    logic               zero_q;
    logic [TOT_W-1:0]   product_q;
    range_flags_t       flags_q;
    logic               done_q;

    logic               accept;
    logic [2*FRAC_W-1:0] mul_prod;
    logic               mul_fin;
    logic [TOT_W-1:0]   nr_result;
    range_flags_t       nr_flags;

    assign accept = start && (state_q == ST_IDLE);

    fpmul_shiftadd #(.W(FRAC_W)) u_frac (
        .clk    (clk),
        .rst    (rst),
        .load   (accept),
        .a_i    (opa[FRAC_W-1:0]),
        .b_i    (opb[FRAC_W-1:0]),
        .prod_o (mul_prod),
        .fin_o  (mul_fin)
    );

    fpmul_normround #(.EXP_W(EXP_W), .W(FRAC_W)) u_norm (
        .sign_i   (sign_q),
        .ea_i     (ea_q),
        .eb_i     (eb_q),
        .zero_i   (zero_q),
        .prod_i   (mul_prod),
        .result_o (nr_result),
        .flags_o  (nr_flags)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q   <= ST_IDLE;
            sign_q    <= 1'b0;
            ea_q      <= '0;
            eb_q      <= '0;
            zero_q    <= 1'b0;
            product_q <= '0;
            flags_q   <= '0;
            done_q    <= 1'b0;
        end else begin
            done_q <= 1'b0;
            case (state_q)
                ST_IDLE: begin
                    if (start) begin
                        sign_q  <= opa[TOT_W-1] ^ opb[TOT_W-1];
                        ea_q    <= opa[TOT_W-2:FRAC_W];
                        eb_q    <= opb[TOT_W-2:FRAC_W];
                        zero_q  <= (opa[FRAC_W-1:0] == '0) || (opb[FRAC_W-1:0] == '0);
                        state_q <= ST_RUN;
                    end
                end
                ST_RUN: begin
                    if (mul_fin) begin
                        product_q <= nr_result;
                        flags_q   <= nr_flags;
                        done_q    <= 1'b1;
                        state_q   <= ST_IDLE;
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    assign product   = product_q;
    assign done      = done_q;
    assign overflow  = flags_q.ovf;
    assign underflow = flags_q.unf;

    // R9: completion is a single-cycle pulse
    assert_done_pulse_R9: assert property (@(posedge clk) disable iff (rst)
        done_q |=> !done_q);

    // R10: outputs move only when the fraction engine finishes
    assert_hold_R10: assert property (@(posedge clk) disable iff (rst)
        !mul_fin |=> ($stable(product_q) && $stable(flags_q)));

    // R3, R4: never both range flags at once
    assert_flags_excl_R3: assert property (@(posedge clk) disable iff (rst)
        !(flags_q.ovf && flags_q.unf));

    // R8: a zero operand gives a clean zero result
    assert_zero_result_R8: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_RUN && mul_fin && zero_q) |=>
            (product_q == '0 && !flags_q.ovf && !flags_q.unf));

    // R5: every in-range non-zero result is normalized
    assert_normalized_R5: assert property (@(posedge clk) disable iff (rst)
        (done_q && !flags_q.ovf && !flags_q.unf && product_q != '0) |->
            product_q[FRAC_W-1]);

    // R11: operand context is frozen while a multiply runs
    assert_busy_ignore_R11: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_RUN) |=> ($stable(sign_q) && $stable(ea_q) &&
                                 $stable(eb_q) && $stable(zero_q)));

endmodule

// File: tb/fpmul_core_tb.sv
module fpmul_core_tb;
    localparam int EXP_W  = 7;
    localparam int FRAC_W = 24;
    localparam int TOT_W  = 1 + EXP_W + FRAC_W;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             start = 1'b0;
    logic [TOT_W-1:0] opa = '0;
    logic [TOT_W-1:0] opb = '0;
    logic [TOT_W-1:0] product;
    logic             done;
    logic             overflow;
    logic             underflow;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    fpmul_core #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_dut (
        .clk       (clk),
        .rst       (rst),
        .start     (start),
        .opa       (opa),
        .opb       (opb),
        .product   (product),
        .done      (done),
        .overflow  (overflow),
        .underflow (underflow)
    );

    task automatic chk(input string tag, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    // behavioural reference: {ovf, unf, result}
    function automatic logic [33:0] ref_mul(input logic [31:0] a, input logic [31:0] b);
        longint p;
        longint m;
        int     e;
        logic   sg;
        logic   g;
        logic   s;
        sg = a[31] ^ b[31];
        if (a[23:0] == 24'h0 || b[23:0] == 24'h0) return '0;
        p = longint'(a[23:0]) * longint'(b[23:0]);
        e = int'(a[30:24]) + int'(b[30:24]) - 64;
        if (p[47] == 1'b0) begin
            p = p << 1;
            e = e - 1;
        end
        m = p >> 24;
        g = p[23];
        s = (p & 64'h7FFFFF) != 0;
        if (g && (s || m[0])) m = m + 1;
        if (m == (longint'(1) << 24)) begin
            m = longint'(1) << 23;
            e = e + 1;
        end
        if (e > 127) return {2'b10, sg, 7'h7F, 24'hFFFFFF};
        if (e < 0)   return {2'b01, 32'h0};
        return {2'b00, sg, e[6:0], m[23:0]};
    endfunction

    function automatic logic [47:0] find_carry_pair();
        for (longint a = 64'hB504F3; a < 64'hB60000; a++) begin
            longint b;
            longint p;
            b = ((longint'(1) << 47) - 1) / a;
            p = a * b;
            if (b >= 64'h800000 && b <= 64'hFFFFFF &&
                p >= (longint'(1) << 47) - (longint'(1) << 22))
                return {a[23:0], b[23:0]};
        end
        return '0;
    endfunction

    // cycle model
    string        cur_tag = "R1";
    string        pend_tag = "R12";
    bit           m_busy = 0;
    int           m_cnt = 0;
    logic [33:0]  m_pending = '0;
    logic [33:0]  m_out = '0;
    logic         exp_done;

    always @(negedge clk) begin
        if (rst) begin
            m_busy = 0;
            m_out  = '0;
        end else begin
            exp_done = 1'b0;
            if (m_busy) begin
                m_cnt--;
                if (m_cnt == 0) begin
                    m_busy   = 0;
                    exp_done = 1'b1;
                    m_out    = m_pending;
                end
            end
            chk(exp_done ? pend_tag : "R9", "done", 64'(done), 64'(exp_done));
            chk(exp_done ? pend_tag : "R10", "product", 64'(product), 64'(m_out[31:0]));
            chk(exp_done ? pend_tag : "R10", "overflow", 64'(overflow), 64'(m_out[33]));
            chk(exp_done ? pend_tag : "R10", "underflow", 64'(underflow), 64'(m_out[32]));
            if (start && !m_busy) begin
                m_busy    = 1;
                m_cnt     = FRAC_W + 2;
                m_pending = ref_mul(opa, opb);
                pend_tag  = cur_tag;
            end
        end
    end

    task automatic issue(input logic [31:0] a, input logic [31:0] b, input string tag);
        @(posedge clk); #1;
        opa = a; opb = b; start = 1'b1; cur_tag = tag;
        @(posedge clk); #1;
        start = 1'b0;
        repeat (FRAC_W + 3) @(posedge clk);
    endtask

    function automatic logic [31:0] mk(input logic s, input int e, input logic [23:0] f);
        return {s, e[6:0], f};
    endfunction

    initial begin
        logic [47:0] cp;
        repeat (4) @(posedge clk);
        #1 rst = 1'b0;
        @(negedge clk);
        // R12: reset state
        chk("R12", "done", 64'(done), 64'h0);
        chk("R12", "product", 64'(product), 64'h0);
        chk("R12", "flags", 64'({overflow, underflow}), 64'h0);

        // R1, R2: basic products with each sign combination
        issue(mk(0, 66, 24'hC00000), mk(0, 62, 24'hC00000), "R1");
        issue(mk(1, 70, 24'hA00000), mk(0, 60, 24'hE00000), "R2");
        issue(mk(0, 64, 24'hF12345), mk(1, 65, 24'h9ABCDE), "R2");
        issue(mk(1, 64, 24'h876543), mk(1, 64, 24'hFEDCBA), "R2");
        // R5: normalizing shift
        issue(mk(0, 64, 24'h800000), mk(0, 64, 24'h800000), "R5");
        // R6: halfway ties, odd and even kept LSB
        issue(mk(0, 64, 24'h800001), mk(0, 64, 24'hC00000), "R6");
        issue(mk(0, 64, 24'h800003), mk(0, 64, 24'hC00000), "R6");
        // R7: rounding carry, and carry into overflow
        cp = find_carry_pair();
        issue(mk(0, 64, cp[47:24]), mk(1, 64, cp[23:0]), "R7");
        issue(mk(0, 127, cp[47:24]), mk(0, 65, cp[23:0]), "R7");
        // R3: overflow, and stored exponent exactly 127
        issue(mk(1, 127, 24'hFFFFFF), mk(0, 127, 24'hFFFFFF), "R3");
        issue(mk(0, 127, 24'hC00000), mk(0, 64, 24'hC00000), "R3");
        // R4: underflow, and stored exponent exactly 0
        issue(mk(0, 0, 24'h800000), mk(1, 0, 24'h900000), "R4");
        issue(mk(0, 1, 24'h800000), mk(0, 64, 24'h800000), "R4");
        // R8: zero fractions
        issue(32'h0, mk(0, 70, 24'hABCDEF), "R8");
        issue(mk(1, 90, 24'hC00000), mk(1, 33, 24'h0), "R8");

        // R11: second start during busy is ignored
        @(posedge clk); #1;
        opa = mk(0, 64, 24'hC00000); opb = mk(0, 64, 24'hC00000);
        start = 1'b1; cur_tag = "R11";
        @(posedge clk); #1;
        start = 1'b0;
        repeat (5) @(posedge clk); #1;
        opa = mk(1, 10, 24'h812345); opb = mk(0, 120, 24'hF00001);
        start = 1'b1;
        @(posedge clk); #1;
        start = 1'b0;
        // R9: new start in the done cycle is taken
        repeat (FRAC_W - 5) @(posedge clk); #1;
        opa = mk(0, 80, 24'hB00000); opb = mk(1, 50, 24'hD00000);
        start = 1'b1; cur_tag = "R9";
        @(posedge clk); #1;
        start = 1'b0;
        repeat (FRAC_W + 3) @(posedge clk);

        // R10: operand changes while idle leave outputs alone
        opa = mk(1, 3, 24'hFFFFFF); opb = mk(1, 4, 24'h800000);
        repeat (10) @(posedge clk);

        // random normalized operands
        for (int i = 0; i < 200; i++) begin
            logic [31:0] ra;
            logic [31:0] rb;
            ra = $urandom; rb = $urandom;
            ra[23] = 1'b1; rb[23] = 1'b1;
            issue(ra, rb, "R1");
        end

        repeat (4) @(posedge clk);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL R9 watchdog: actual=hung expected=finished");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule